// File: doc/BRIEF.md
# Rectified Sine Reference Generator

This block produces the magnitude of a 50 Hz sine as an unsigned code, one new sample for each pulse of a 1 MHz sample enable. Only one quarter of a period is held in a constant table. A small up/down sweeper walks the table address up to its top entry and back down to zero, which gives one positive hump per half period. A separate polarity flag tells downstream switching logic which half of the period is active. The output therefore never goes negative: sign information travels only on the flag.

A consumer feeds the magnitude to a bank of level comparators and uses the flag to steer the bridge polarity. Each new sample comes with a one-clock valid strobe, so the consumer can sample on the strobe without tracking the enable itself.

Top module: `hrect_ref_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, the magnitude is 0, the polarity flag is low and the valid strobe is low.
- R2: The valid strobe is high for exactly one clock in the cycle after each clock in which the sample enable is high, and low otherwise. Magnitude and flag change only in a cycle where the valid strobe is high.
- R3: The n-th valid sample after reset (n counted from 0) shows sequence position p = n mod 20000. With h = p mod 10000, the table address is h for h < 5000 and 9999 - h for h >= 5000.
- R4: Table entry a holds round(650 * sin(pi/2 * (a + 0.5) / 5000)). The largest value, 650, appears at address 4999.
- R5: The polarity flag is low for positions 0 to 9999 and high for positions 10000 to 19999. Rising edges of the flag are exactly 20000 samples apart.
- R6: Within every half period the magnitude at position h equals the magnitude at position 9999 - h, and this holds in both the low-flag and the high-flag half.
- R7: A sample enable held high on consecutive clocks advances the sequence by one position on every clock, with no position skipped.
- R8: The magnitude never exceeds 650.
- R9: A reset in the middle of a period restarts the sequence, so the first valid sample after it is position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1m | input | 1 | Sample enable; one new sample per high cycle |
| ref_mag | output | 10 | Unsigned magnitude of the reference sine |
| half_sel | output | 1 | Polarity flag: low in the first half period, high in the second |
| ref_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
The bench builds the block with its default parameters: a 5000-entry quarter table and a peak of 650. The sample enable is driven much faster than 1 MHz relative to the clock, first back to back and then in irregular bursts and gaps. This brings more than two full 20000-sample periods into reach. The run therefore covers both turnarounds of the sweep, both flag edges, the peak entry and a reset taken partway through a period.

// File: rtl/hrect_pkg.sv
package hrect_pkg;

    localparam int  DEF_QUARTER_LEN = 5000;
    localparam int  DEF_PEAK        = 650;
    localparam real HALF_PI         = 1.5707963267948966;

    // Direction of the address sweep inside one half period
    typedef enum logic {
        SWEEP_UP   = 1'b0,
        SWEEP_DOWN = 1'b1
    } sweep_dir_e;

    // Rounded sample of the quarter wave at the centre of slot k
    function automatic int quarter_sample(int k, int qlen, int peak);
        real ang;
        ang = HALF_PI * (real'(k) + 0.5) / real'(qlen);
        return $rtoi(real'(peak) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/hrect_rom.sv
module hrect_rom
    import hrect_pkg::*;
#(
    parameter int QUARTER_LEN = DEF_QUARTER_LEN,
    parameter int PEAK        = DEF_PEAK,
    parameter int ADDR_W      = $clog2(QUARTER_LEN),
    parameter int MAG_W       = $clog2(PEAK + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MAG_W-1:0]  data
);

    logic [MAG_W-1:0] table_q [QUARTER_LEN];

    // Constant contents generated at elaboration
    initial begin
        for (int i = 0; i < QUARTER_LEN; i++) begin
            table_q[i] = MAG_W'(quarter_sample(i, QUARTER_LEN, PEAK));
        end
    end

    assign data = table_q[addr];

endmodule

// File: rtl/hrect_seq.sv
module hrect_seq
    import hrect_pkg::*;
#(
    parameter int QUARTER_LEN = DEF_QUARTER_LEN,
    parameter int ADDR_W      = $clog2(QUARTER_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              half
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(QUARTER_LEN - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        sweep_dir_e        dir;
        logic              half;
    } seq_state_t;

    seq_state_t cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        if (advance) begin
            unique case (cur_q.dir)
                SWEEP_UP: begin
                    // top entry is shown twice: once rising, once falling
                    if (cur_q.addr == TOP_ADDR) nxt.dir  = SWEEP_DOWN;
                    else                        nxt.addr = cur_q.addr + 1'b1;
                end
                SWEEP_DOWN: begin
                    if (cur_q.addr == '0) begin
                        nxt.dir  = SWEEP_UP;
                        nxt.half = ~cur_q.half;
                    end else begin
                        nxt.addr = cur_q.addr - 1'b1;
                    end
                end
                default: nxt = cur_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.addr <= '0;
            cur_q.dir  <= SWEEP_UP;
            cur_q.half <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign addr = cur_q.addr;
    assign half = cur_q.half;

endmodule

// File: rtl/hrect_ref_top.sv
module hrect_ref_top
    import hrect_pkg::*;
#(
    parameter  int QUARTER_LEN = DEF_QUARTER_LEN,
    parameter  int PEAK        = DEF_PEAK,
    localparam int MAG_W       = $clog2(PEAK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1m,
    output logic [MAG_W-1:0] ref_mag,
    output logic             half_sel,
    output logic             ref_valid
);

    localparam int ADDR_W = $clog2(QUARTER_LEN);

    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             half;
        logic             valid;
    } out_stage_t;

    logic [ADDR_W-1:0] seq_addr;
    logic              seq_half;
    logic [MAG_W-1:0]  rom_data;
    out_stage_t        out_q;

    hrect_seq #(
        .QUARTER_LEN (QUARTER_LEN),
        .ADDR_W      (ADDR_W)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .advance (tick_1m),
        .addr    (seq_addr),
        .half    (seq_half)
    );

    hrect_rom #(
        .QUARTER_LEN (QUARTER_LEN),
        .PEAK        (PEAK),
        .ADDR_W      (ADDR_W),
        .MAG_W       (MAG_W)
    ) rom_i (
        .addr (seq_addr),
        .data (rom_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= tick_1m;
            if (tick_1m) begin
                out_q.mag  <= rom_data;
                out_q.half <= seq_half;
            end
        end
    end

    assign ref_mag   = out_q.mag;
    assign half_sel  = out_q.half;
    assign ref_valid = out_q.valid;

endmodule

// File: rtl/hrect_ref_chk.sv
module hrect_ref_chk #(
    parameter  int QUARTER_LEN = 5000,
    parameter  int PEAK        = 650,
    localparam int MAG_W       = $clog2(PEAK + 1),
    localparam int HALF_LEN    = 2 * QUARTER_LEN
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_1m,
    input logic [MAG_W-1:0] ref_mag,
    input logic             half_sel,
    input logic             ref_valid
);

    int   run_len;
    logic last_half;
    logic flip;

    assign flip = ref_valid && (half_sel != last_half);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len   <= 0;
            last_half <= 1'b0;
        end else if (ref_valid) begin
            last_half <= half_sel;
            run_len   <= flip ? 1 : run_len + 1;
        end
    end

    // R2
    valid_follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick_1m |=> ref_valid);

    // R2
    valid_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> $past(tick_1m));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_1m |=> ($stable(ref_mag) && $stable(half_sel)));

    // R8
    mag_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ref_mag <= MAG_W'(PEAK));

    // R5
    half_length_chk: assert property (@(posedge clk) disable iff (rst)
        flip |-> (run_len == HALF_LEN));

endmodule

bind hrect_ref_top hrect_ref_chk #(
    .QUARTER_LEN (QUARTER_LEN),
    .PEAK        (PEAK)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_1m   (tick_1m),
    .ref_mag   (ref_mag),
    .half_sel  (half_sel),
    .ref_valid (ref_valid)
);

// File: tb/hrect_ref_top_tb_top.sv
module hrect_ref_top_tb_top;

    localparam int QL = 5000;
    localparam int PK = 650;
    localparam int HL = 2 * QL;
    localparam int FL = 2 * HL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [9:0] mag;
    logic       half;
    logic       valid;

    always #4 clk = ~clk;

    hrect_ref_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_1m   (tick),
        .ref_mag   (mag),
        .half_sel  (half),
        .ref_valid (valid)
    );

    int    n_chk = 0;
    int    n_err = 0;
    int    k = 0;
    int    e_mag = 0;
    bit    e_half = 1'b0;
    bit    e_valid = 1'b0;
    int    obs [HL];
    int    last_rise = -1;
    bit    prev_half = 1'b0;
    string tag_valid = "R2";
    string tag_mag = "R3";

    function automatic int model_mag(int p);
        int h;
        int a;
        h = p % HL;
        a = (h < QL) ? h : (HL - 1 - h);
        return $rtoi(650.0 * $sin(3.141592653589793 * (real'(a) + 0.5) / real'(HL)) + 0.5);
    endfunction

    function automatic bit model_half(int p);
        return (p % FL) >= HL;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_half();
        bit sym = 1'b1;
        int mx = 0;
        for (int i = 0; i < HL; i++) begin
            if (obs[i] != obs[HL - 1 - i]) sym = 1'b0;
            if (obs[i] > mx) mx = obs[i];
        end
        chk(sym, "R6 half-wave symmetry", int'(sym), 1);
        chk(mx == PK, "R4 peak value", mx, PK);
        chk(obs[QL - 1] == PK, "R4 peak at top address", obs[QL - 1], PK);
    endtask

    // One clock: check outputs, then drive the enable for the next edge
    task automatic cyc(bit t);
        int idx;
        @(negedge clk);
        chk(valid == e_valid, tag_valid, int'(valid), int'(e_valid));
        chk(mag == 10'(e_mag), tag_mag, int'(mag), e_mag);
        chk(half == e_half, "R5 polarity flag", int'(half), int'(e_half));
        if (valid) begin
            idx = k - 1;
            obs[idx % HL] = int'(mag);
            if (half && !prev_half) begin
                if (last_rise >= 0)
                    chk(idx - last_rise == FL, "R5 flag period", idx - last_rise, FL);
                last_rise = idx;
            end
            prev_half = half;
            if ((idx % HL) == HL - 1) finish_half();
        end
        tick = t;
        if (t) begin
            e_mag   = model_mag(k);
            e_half  = model_half(k);
            e_valid = 1'b1;
            k++;
        end else begin
            e_valid = 1'b0;
        end
    endtask

    task automatic do_reset(int n);
        @(negedge clk);
        rst  = 1'b1;
        tick = 1'b0;
        repeat (n) @(negedge clk);
        // R1: state while reset is held
        chk(mag == 10'd0, "R1 reset magnitude", int'(mag), 0);
        chk(half == 1'b0, "R1 reset flag", int'(half), 0);
        chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
        rst       = 1'b0;
        k         = 0;
        e_mag     = 0;
        e_half    = 1'b0;
        e_valid   = 1'b0;
        prev_half = 1'b0;
        last_rise = -1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", k, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset(3);
        // R1: first cycles after reset, no enable yet
        cyc(1'b0);
        cyc(1'b0);

        // R7: enable held high back to back
        tag_valid = "R7";
        for (int i = 0; i < 12000; i++) cyc(1'b1);
        tag_valid = "R2";

        // R2/R3/R5/R6: irregular enable with gaps and bursts
        while (k < 41000) begin
            if (($urandom % 50) == 0) begin
                cyc(1'b1);
                repeat (1 + ($urandom % 6)) cyc(1'b0);
            end else begin
                cyc(($urandom % 3) != 0);
            end
        end
        cyc(1'b0);

        // R9: reset partway through a period
        tag_mag = "R9";
        do_reset(2);
        cyc(1'b0);
        for (int i = 0; i < 40; i++) cyc(i % 2 == 0);
        cyc(1'b0);
        chk(k == 20, "R9 restart count", k, 20);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule